// File: doc/BRIEF.md
# Pseudo-Random Manchester Line Transmitter with Error Injection

This block produces a repeating pseudo-random data stream from a linear feedback shift register and sends it out Manchester encoded, one data bit every DIVIDER system clocks. A free-running timing counter gives a bit strobe, a half-bit line clock and a mid-bit strobe. The line clock is XORed with the data to form the encoded line signal.

A counter of transmitted bits marks out bursts and can be cleared at any time without disturbing the sequence. For loop-back self-test, an error injector can invert one data bit at a selectable spacing. Eight spacings give error rates from 1% to 50%. The clean data, the line clock and the mid-bit strobe are brought out registered, so that a downstream comparator can line them up with recovered data.

Top module: `prbs_manch_tx`

## Requirements
- R1: A timing counter runs 0 to DIVIDER-1 and wraps. The bit strobe is active at count DIVIDER-1, the line clock is high for counts 0 to DIVIDER/2-1, and the mid-bit strobe is active at count DIVIDER/2-1. `man_bit_clk` and `transmit_bit_enable` are these two signals delayed by one register stage.
- R2: The shift register is N bits wide and starts at all ones. On each bit strobe it shifts toward its MSB. Its new LSB is the XOR of the register bits selected by TAP_MASK, and its MSB is the data bit. With N=4 and TAP_MASK=4'b1100 the data repeats every 15 bits, 8 of them ones.
- R3: `nrz` is the registered data bit (the MSB), without any injected error.
- R4: `burst_count` (N bits, wrapping) increments on each bit strobe. `clr_burst` zeroes it at the next edge and takes priority over counting. Clearing does not alter the data sequence.
- R5: While `err_enable` is 0, no data bit is inverted on `man_tx`.
- R6: An error counter advances on each bit strobe and returns to 0 after it reaches the spacing picked by `err_sel`: 0→99, 1→49, 2→19, 3→9, 4→4, 5→3, 6→2, 7→1. Errors are injected for exactly the bit period in which the counter equals the spacing, when `err_enable` is 1.
- R7: `man_tx` is a register loaded with data XOR error XOR line clock.
- R8: Reset is synchronous and active high. After a reset edge all outputs are 0, the counters are 0 and the shift register holds all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_burst | input | 1 | Clears the burst bit counter |
| err_enable | input | 1 | Enables error injection |
| err_sel | input | 3 | Error spacing select |
| man_tx | output | 1 | Manchester encoded line output |
| nrz | output | 1 | Registered clean data bit |
| man_bit_clk | output | 1 | Registered line (half-bit) clock |
| transmit_bit_enable | output | 1 | Registered mid-bit strobe |
| burst_count | output | N | Bits sent since last clear |

## Verification
The error spacing is measured end to end. The bench counts cycles in which `man_tx` XOR `man_bit_clk` differs from `nrz`, over exactly 200 bit periods, for several select codes and with injection off. An off-by-one wrap in the error counter or a mistaken spacing table shifts this count. A clear is pulsed mid-run against a reference model that keeps the sequence running, so a design that also reseeds its shift register on a clear shows a data mismatch. The shift register is checked for its 15-bit period and its count of ones, which catches a wrong tap or shift direction. The burst counter is allowed to wrap, which catches a counter sized or bounded wrongly.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int GAP_W = 7;

  function automatic logic [GAP_W-1:0] gap_of(input logic [2:0] sel);
    logic [GAP_W-1:0] g;
    case (sel)
      3'd0:    g = 7'd99;
      3'd1:    g = 7'd49;
      3'd2:    g = 7'd19;
      3'd3:    g = 7'd9;
      3'd4:    g = 7'd4;
      3'd5:    g = 7'd3;
      3'd6:    g = 7'd2;
      default: g = 7'd1;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/mtx_timing.sv
module mtx_timing #(
  parameter int DIVIDER = 10
) (
  input  logic clk,
  input  logic rst,
  output logic bit_en,
  output logic bit_clk,
  output logic mid_en
);
  localparam int CW = (DIVIDER > 1) ? $clog2(DIVIDER) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIVIDER - 1);
  localparam logic [CW-1:0] HALF = CW'(DIVIDER / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign bit_en  = (cnt == LAST);
  assign bit_clk = (cnt < HALF);
  assign mid_en  = (cnt == HALF - 1'b1);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= LAST); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) bit_en |=> (cnt == '0)); // R1
endmodule

// File: rtl/mtx_lfsr.sv
module mtx_lfsr #(
  parameter int          N        = 10,
  parameter logic [N-1:0] TAP_MASK = 10'b1001000000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic         clr_burst,
  output logic         data_bit,
  output logic [N-1:0] burst_count
);
  logic [N-1:0] sreg;
  logic         fb;

  assign fb = ^(sreg & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst)         sreg <= '1;
    else if (bit_en) sreg <= {sreg[N-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst)            burst_count <= '0;
    else if (clr_burst) burst_count <= '0;
    else if (bit_en)    burst_count <= burst_count + 1'b1;
  end

  assign data_bit = sreg[N-1];

  AST_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst) sreg != '0); // R2
  AST_HOLD_SREG:  assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(sreg)); // R2
  AST_CLR_BURST:  assert property (@(posedge clk) disable iff (rst) clr_burst |=> (burst_count == '0)); // R4
endmodule

// File: rtl/mtx_errgen.sv
module mtx_errgen
  import mtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       err_enable,
  input  logic [2:0] err_sel,
  output logic       error
);
  logic [GAP_W-1:0] ecnt;
  logic [GAP_W-1:0] gap;
  logic             hit;

  assign gap = gap_of(err_sel);
  assign hit = (ecnt >= gap);

  always_ff @(posedge clk) begin
    if (rst)         ecnt <= '0;
    else if (bit_en) ecnt <= hit ? '0 : ecnt + 1'b1;
  end

  assign error = err_enable & hit;

  AST_ECNT_BOUND: assert property (@(posedge clk) disable iff (rst) ecnt <= 7'd99); // R6
  AST_ECNT_STEP:  assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable(ecnt)); // R6
endmodule

// File: rtl/prbs_manch_tx.sv
module prbs_manch_tx #(
  parameter int           DIVIDER  = 10,
  parameter int           N        = 10,
  parameter logic [N-1:0] TAP_MASK = 10'b1001000000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_burst,
  input  logic         err_enable,
  input  logic [2:0]   err_sel,
  output logic         man_tx,
  output logic         nrz,
  output logic         man_bit_clk,
  output logic         transmit_bit_enable,
  output logic [N-1:0] burst_count
);
  logic bit_en, bit_clk, mid_en, data_bit, error;

  mtx_timing #(.DIVIDER(DIVIDER)) u_timing (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_clk(bit_clk), .mid_en(mid_en)
  );

  mtx_lfsr #(.N(N), .TAP_MASK(TAP_MASK)) u_lfsr (
    .clk(clk), .rst(rst), .bit_en(bit_en), .clr_burst(clr_burst),
    .data_bit(data_bit), .burst_count(burst_count)
  );

  mtx_errgen u_err (
    .clk(clk), .rst(rst), .bit_en(bit_en), .err_enable(err_enable),
    .err_sel(err_sel), .error(error)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      man_tx              <= 1'b0;
      nrz                 <= 1'b0;
      man_bit_clk         <= 1'b0;
      transmit_bit_enable <= 1'b0;
    end else begin
      man_tx              <= (data_bit ^ error) ^ bit_clk;
      nrz                 <= data_bit;
      man_bit_clk         <= bit_clk;
      transmit_bit_enable <= mid_en;
    end
  end

  AST_TBE_PULSE: assert property (@(posedge clk) disable iff (rst) transmit_bit_enable |=> !transmit_bit_enable); // R1
  AST_NO_ERR_OFF: assert property (@(posedge clk) disable iff (rst) !err_enable |=> ((man_tx ^ man_bit_clk) == nrz)); // R5
endmodule

// File: tb/prbs_manch_tx_test.sv
module prbs_manch_tx_test;
  localparam int DIV = 10;
  localparam int NB  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_burst = 1'b0;
  logic err_enable = 1'b0;
  logic [2:0] err_sel = 3'd0;
  logic man_tx, nrz, man_bit_clk, transmit_bit_enable;
  logic [NB-1:0] burst_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prbs_manch_tx #(.DIVIDER(DIV), .N(NB), .TAP_MASK(4'b1100)) uut (
    .clk(clk), .rst(rst), .clr_burst(clr_burst), .err_enable(err_enable),
    .err_sel(err_sel), .man_tx(man_tx), .nrz(nrz), .man_bit_clk(man_bit_clk),
    .transmit_bit_enable(transmit_bit_enable), .burst_count(burst_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int gap(input logic [2:0] s);
    case (s)
      3'd0: return 99; 3'd1: return 49; 3'd2: return 19; 3'd3: return 9;
      3'd4: return 4;  3'd5: return 3;  3'd6: return 2;  default: return 1;
    endcase
  endfunction

  // scoreboard reference model
  typedef struct packed {
    logic tx; logic d; logic bc; logic tbe; logic [NB-1:0] pc;
  } exp_t;
  exp_t q[$];
  int m_cnt = 0;
  logic [NB-1:0] m_sr = '1;
  logic [NB-1:0] m_pc = '0;
  int m_ec = 0;

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_cnt = 0; m_sr = '1; m_pc = '0; m_ec = 0;
      e = '0;
    end else begin
      logic bc, be, er, fb;
      bc = (m_cnt < DIV/2);
      be = (m_cnt == DIV-1);
      er = err_enable && (m_ec >= gap(err_sel));
      e.tx = m_sr[NB-1] ^ er ^ bc;
      e.d = m_sr[NB-1];
      e.bc = bc;
      e.tbe = (m_cnt == DIV/2-1);
      fb = m_sr[3] ^ m_sr[2];
      if (be) begin
        m_sr = {m_sr[NB-2:0], fb};
        m_ec = (m_ec >= gap(err_sel)) ? 0 : m_ec + 1;
      end
      if (clr_burst) m_pc = '0;
      else if (be) m_pc = m_pc + 1'b1;
      m_cnt = be ? 0 : m_cnt + 1;
      e.pc = m_pc;
    end
    q.push_back(e);
  end

  always @(negedge clk) begin
    if (q.size() > 0 && !done) begin
      exp_t e;
      e = q.pop_front();
      chk("R7 man_tx", int'(man_tx), int'(e.tx));
      chk("R3 nrz", int'(nrz), int'(e.d));
      chk("R1 man_bit_clk", int'(man_bit_clk), int'(e.bc));
      chk("R1 transmit_bit_enable", int'(transmit_bit_enable), int'(e.tbe));
      chk("R4 burst_count", int'(burst_count), int'(e.pc));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset man_tx", int'(man_tx), 0);
    chk("R8 reset nrz", int'(nrz), 0);
    chk("R8 reset burst_count", int'(burst_count), 0);
    chk("R8 reset tbe", int'(transmit_bit_enable), 0);
    rst = 1'b0;
  endtask

  // R5 R6: errored cycles over exactly 200 bit periods from reset
  task automatic run_rate(input logic en, input logic [2:0] s, input int exp_cycles);
    int n = 0;
    err_enable = en; err_sel = s;
    do_reset();
    for (int i = 0; i < 200*DIV; i++) begin
      @(negedge clk);
      if ((man_tx ^ man_bit_clk) != nrz) n++;
    end
    chk(en ? "R6 error spacing" : "R5 injection off", n, exp_cycles);
  endtask

  initial begin
    logic s[30];
    int ones;
    bit same;
    do_reset();
    // R2 period and weight
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); s[i] = nrz;
      repeat (DIV-1) @(negedge clk);
    end
    ones = 0; same = 1;
    for (int i = 0; i < 15; i++) begin
      if (s[i]) ones++;
      if (s[i] != s[i+15]) same = 0;
    end
    chk("R2 period 15", int'(same), 1);
    chk("R2 ones per period", ones, 8);
    chk("R2 first bit from seed", int'(s[0]), 1);
    // R4 clear mid-run, burst counter wraps
    repeat (37) @(negedge clk);
    clr_burst = 1'b1; @(negedge clk); clr_burst = 1'b0;
    chk("R4 cleared", int'(burst_count), 0);
    repeat (300) @(negedge clk);
    clr_burst = 1'b1; repeat (25) @(negedge clk); clr_burst = 1'b0;
    chk("R4 clear holds", int'(burst_count), 0);
    repeat (100) @(negedge clk);
    run_rate(1'b0, 3'd7, 0);
    run_rate(1'b1, 3'd3, 200);
    run_rate(1'b1, 3'd7, 1000);
    run_rate(1'b1, 3'd0, 20);
    run_rate(1'b1, 3'd4, 400);
    run_rate(1'b1, 3'd6, 660);
    // switch code mid-run, scoreboard follows
    err_sel = 3'd5; repeat (500) @(negedge clk);
    err_enable = 1'b0; repeat (200) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule